// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer and turns one read or write command into the stream of column addresses that the burst covers. The controller presents the low field bits of the mode word, the starting column and a one-cycle start strobe carrying the read/write direction. The block captures the mode fields at that moment and then walks the beats in the programmed order: sequential, interleaved, or a free-running full-page sweep.

For reads, the first beat appears exactly CAS-latency clocks after the command, and the data bus drive enable is high only while read beats are valid. For writes, beats begin on the clock after the command. A terminate strobe cuts any burst short. A new start abandons the burst in flight and begins the new one at once. A last-beat flag marks the final beat of a fixed-length burst, so the controller can chain the next command.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Burst-length field mode_word[2:0] selects the beat count: 000=1, 001=2, 010=4, 011=8. The reserved codes 100, 101 and 110 give a single beat.
- R2: With mode_word[3]=0, beat k carries the starting column with its low log2(L) bits replaced by (low bits + k) mod L. The upper bits are unchanged.
- R3: With mode_word[3]=1 and a fixed length L, beat k carries the starting column with its low log2(L) bits XORed with k.
- R4: Code 111 selects full page. Beats step sequentially through all 2^COL_W columns and wrap around. mode_word[3] has no effect. The burst runs until terminated, and last_beat stays low.
- R5: For a read issued in cycle 0, the first beat_valid is in cycle CL. CL comes from mode_word[6:4]: 010=2, 011=3, any other code =3.
- R6: For a write issued in cycle 0, the first beat_valid is in cycle 1, and its beat_col equals the start column. The CAS-latency field has no effect on writes.
- R7: last_beat is high exactly on the final beat of a fixed-length burst, together with beat_valid.
- R8: bus_drive is high exactly while a read burst's beats are valid. It is low for writes and falls in the cycle after the last read beat.
- R9: A term sampled while start is low ends the burst, including one still waiting out its latency. No beat_valid follows that edge.
- R10: A start during a burst abandons it. Timing and order follow the new command only.
- R11: During and straight after reset, beat_valid, last_beat and bus_drive are low.
- R12: The mode fields, direction and column are captured with start. Later changes on those inputs do not alter the burst in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 7 | Mode fields: [2:0] length, [3] wrap order, [6:4] CAS latency |
| start | input | 1 | Command strobe; begins a burst |
| is_read | input | 1 | Direction of the command: 1 read, 0 write |
| start_col | input | COL_W | Starting column of the burst |
| term | input | 1 | Burst terminate strobe |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | Current beat is live |
| last_beat | output | 1 | Current beat is the final one |
| bus_drive | output | 1 | Data bus drive enable for read data |

## Verification
A wrong beat index or base column shows up as a bad beat_col on the very beat where it diverges, because each beat's column is derived from captured state alone. A latency counter loaded with the wrong value moves the first beat_valid away from cycle CL, so the error is visible within three clocks of the command. A stale active flag after termination or after the final beat leaves beat_valid or bus_drive high one cycle too long. Full-page runs cross the column wrap point, so an index that saturates instead of rolling over fails right at the wrap.

// File: rtl/scg_pkg.sv
package scg_pkg;

  localparam int MODE_W   = 7;
  localparam int LEN_LSB  = 0;
  localparam int WRAP_BIT = 3;
  localparam int CL_LSB   = 4;

  localparam logic [2:0] LEN_ONE  = 3'b000;
  localparam logic [2:0] LEN_TWO  = 3'b001;
  localparam logic [2:0] LEN_FOUR = 3'b010;
  localparam logic [2:0] LEN_EGT  = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  localparam logic [2:0] CL_CODE2 = 3'b010;
  localparam logic [2:0] CL_CODE3 = 3'b011;

  // log2 of burst length for fixed lengths; reserved codes give one beat
  function automatic logic [2:0] len_log2(input logic [2:0] code);
    case (code)
      LEN_ONE:  len_log2 = 3'd0;
      LEN_TWO:  len_log2 = 3'd1;
      LEN_FOUR: len_log2 = 3'd2;
      LEN_EGT:  len_log2 = 3'd3;
      default:  len_log2 = 3'd0;
    endcase
  endfunction

  // CAS latency in clocks; unknown codes fall back to the slower value
  function automatic logic [1:0] cas_clocks(input logic [2:0] code);
    cas_clocks = (code == CL_CODE2) ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/scg_mode_decode.sv
module scg_mode_decode
  import scg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_read,
  output logic [COL_W-1:0]  len_mask,
  output logic              full_page,
  output logic              interleave,
  output logic [1:0]        lead
);

  logic [2:0] len_code;
  logic [2:0] cl_code;
  logic [2:0] lg;
  logic [1:0] cl;

  always_comb begin
    len_code   = mode_word[LEN_LSB +: 3];
    cl_code    = mode_word[CL_LSB +: 3];
    full_page  = (len_code == LEN_PAGE);
    interleave = mode_word[WRAP_BIT] && !full_page;
    lg         = len_log2(len_code);
    cl         = cas_clocks(cl_code);
    lead       = is_read ? (cl - 2'd1) : 2'd0;
  end

  generate
    for (genvar b = 0; b < COL_W; b++) begin : g_mask
      assign len_mask[b] = full_page || (b < int'(lg));
    end
  endgenerate

endmodule

// File: rtl/scg_col_map.sv
module scg_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] len_mask,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] map_col(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] idx,
    input logic [COL_W-1:0] mask,
    input logic             ilv
  );
    logic [COL_W-1:0] low;
    low     = ilv ? (base ^ idx) : (base + idx);
    map_col = (base & ~mask) | (low & mask);
  endfunction

  assign col = map_col(base_col, beat_idx, len_mask, interleave);

endmodule

// File: rtl/scg_beat_seq.sv
module scg_beat_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_full_page,
  input  logic             dec_interleave,
  input  logic [1:0]       dec_lead,
  output logic [COL_W-1:0] cap_base,
  output logic [COL_W-1:0] cap_mask,
  output logic             cap_interleave,
  output logic [COL_W-1:0] beat_idx,
  output logic             emit,
  output logic             emit_last,
  output logic             cap_read,
  output logic             ev_finish
);

  logic       active_q;
  logic [1:0] wait_q;
  logic       full_page_q;

  assign emit      = active_q && (wait_q == 2'd0);
  assign emit_last = emit && !full_page_q && (beat_idx == cap_mask);
  assign ev_finish = !start && active_q && (term || emit_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q       <= 1'b0;
      wait_q         <= 2'd0;
      beat_idx       <= '0;
      cap_base       <= '0;
      cap_mask       <= '0;
      cap_interleave <= 1'b0;
      cap_read       <= 1'b0;
      full_page_q    <= 1'b0;
    end else if (start) begin
      active_q       <= 1'b1;
      wait_q         <= dec_lead;
      beat_idx       <= '0;
      cap_base       <= start_col;
      cap_mask       <= dec_mask;
      cap_interleave <= dec_interleave;
      cap_read       <= is_read;
      full_page_q    <= dec_full_page;
    end else if (ev_finish) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (wait_q != 2'd0) wait_q <= wait_q - 2'd1;
      else                beat_idx <= beat_idx + 1'b1;
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import scg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              is_read,
  input  logic [COL_W-1:0]  start_col,
  input  logic              term,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_valid,
  output logic              last_beat,
  output logic              bus_drive
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full_page;
  logic             dec_interleave;
  logic [1:0]       dec_lead;
  logic [COL_W-1:0] cap_base;
  logic [COL_W-1:0] cap_mask;
  logic             cap_interleave;
  logic [COL_W-1:0] beat_idx;
  logic             emit;
  logic             emit_last;
  logic             cap_read;
  logic             ev_finish;

  scg_mode_decode #(.COL_W(COL_W)) u_dec (
    .mode_word  (mode_word),
    .is_read    (is_read),
    .len_mask   (dec_mask),
    .full_page  (dec_full_page),
    .interleave (dec_interleave),
    .lead       (dec_lead)
  );

  scg_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .is_read        (is_read),
    .term           (term),
    .start_col      (start_col),
    .dec_mask       (dec_mask),
    .dec_full_page  (dec_full_page),
    .dec_interleave (dec_interleave),
    .dec_lead       (dec_lead),
    .cap_base       (cap_base),
    .cap_mask       (cap_mask),
    .cap_interleave (cap_interleave),
    .beat_idx       (beat_idx),
    .emit           (emit),
    .emit_last      (emit_last),
    .cap_read       (cap_read),
    .ev_finish      (ev_finish)
  );

  scg_col_map #(.COL_W(COL_W)) u_map (
    .base_col   (cap_base),
    .beat_idx   (beat_idx),
    .len_mask   (cap_mask),
    .interleave (cap_interleave),
    .col        (beat_col)
  );

  assign beat_valid = emit;
  assign last_beat  = emit_last;
  assign bus_drive  = emit && cap_read;

endmodule

// File: rtl/scg_checker.sv
module scg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             is_read,
  input logic             term,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_valid,
  input logic             last_beat,
  input logic             bus_drive,
  input logic [COL_W-1:0] cap_mask,
  input logic             cap_interleave,
  input logic             ev_finish
);

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  a_r8_drive_only_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> beat_valid);

  a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !start) |=> !beat_valid);

  a_r7_finish_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_finish && !term) |=> !beat_valid);

  a_r6_write_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_read) |=> (beat_valid && !bus_drive && beat_col == $past(start_col)));

  a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_read) |=> !beat_valid);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(start) && !$past(last_beat) && !cap_interleave)
      |-> ((beat_col & cap_mask) == (($past(beat_col) + 1'b1) & cap_mask)));

  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(start))
      |-> ((beat_col & ~cap_mask) == ($past(beat_col) & ~cap_mask)));

endmodule

bind sdram_burst_colgen scg_checker #(.COL_W(COL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .is_read        (is_read),
  .term           (term),
  .start_col      (start_col),
  .beat_col       (beat_col),
  .beat_valid     (beat_valid),
  .last_beat      (last_beat),
  .bus_drive      (bus_drive),
  .cap_mask       (cap_mask),
  .cap_interleave (cap_interleave),
  .ev_finish      (ev_finish)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int COL_W = 8;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [6:0]       mode_word = '0;
  logic             start = 1'b0;
  logic             is_read = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             term = 1'b0;
  logic [COL_W-1:0] beat_col;
  logic             beat_valid;
  logic             last_beat;
  logic             bus_drive;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R11";
  bit    done = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
    .is_read(is_read), .start_col(start_col), .term(term),
    .beat_col(beat_col), .beat_valid(beat_valid), .last_beat(last_beat),
    .bus_drive(bus_drive)
  );

  typedef struct { int col; bit last; } beat_t;
  beat_t q[$];
  int    lead = 0;
  bit    q_rd = 0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic build(input logic [6:0] m, input bit rd, input int base);
    int len; int cl; bit fp; int n; int low;
    fp  = (m[2:0] == 3'b111);
    case (m[2:0])
      3'b001: len = 2;
      3'b010: len = 4;
      3'b011: len = 8;
      default: len = 1;
    endcase
    cl   = (m[6:4] == 3'b010) ? 2 : 3;
    lead = rd ? cl - 1 : 0;
    q_rd = rd;
    n    = fp ? 2 * NCOL : len;
    for (int i = 0; i < n; i++) begin
      beat_t b;
      if (fp) b.col = (base + i) % NCOL;
      else begin
        low = base % len;
        if (m[3]) b.col = base - low + (low ^ i);
        else      b.col = base - low + ((low + i) % len);
      end
      b.last = !fp && (i == len - 1);
      q.push_back(b);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      lead = 0;
    end else if (start) begin
      q.delete();
      build(mode_word, is_read, int'(start_col));
    end else if (term) begin
      q.delete();
    end else if (q.size() > 0) begin
      if (lead > 0) lead--;
      else void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (q.size() > 0) && (lead == 0);
      chk("beat_valid", int'(beat_valid), int'(ev));
      chk("bus_drive", int'(bus_drive), int'(ev && q_rd));
      if (ev) begin
        chk("beat_col", int'(beat_col), q[0].col);
        chk("last_beat", int'(last_beat), int'(q[0].last));
      end else begin
        chk("last_beat", int'(last_beat), 0);
      end
    end
  end

  task automatic issue(input logic [6:0] m, input bit rd, input int col);
    @(negedge clk);
    mode_word = m; is_read = rd; start_col = COL_W'(col); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    chk("reset beat_valid", int'(beat_valid), 0);
    chk("reset bus_drive", int'(bus_drive), 0);
    chk("reset last_beat", int'(last_beat), 0);
    rst_n = 1'b1;

    cur_req = "R1 R2 R6 R7 R8 write len4 seq";
    issue(7'b011_0_010, 1'b0, 8'h2D); idle(6);
    cur_req = "R2 R5 R7 R8 read len8 seq CL2";
    issue(7'b010_0_011, 1'b1, 8'h15); idle(12);
    cur_req = "R3 R5 R7 R8 read len8 interleave CL3";
    issue(7'b011_1_011, 1'b1, 8'h15); idle(12);
    cur_req = "R3 R6 write len4 interleave";
    issue(7'b010_1_010, 1'b0, 8'hC6); idle(6);
    cur_req = "R1 R5 reserved length and CL code";
    issue(7'b111_0_101, 1'b1, 8'h44); idle(6);
    issue(7'b000_1_110, 1'b0, 8'h45); idle(4);
    cur_req = "R1 R6 single and pair";
    issue(7'b010_0_000, 1'b0, 8'h07); idle(3);
    issue(7'b010_1_001, 1'b1, 8'h07); idle(6);
    cur_req = "R4 R9 full page wrap then terminate";
    issue(7'b010_1_111, 1'b1, 8'hF0); idle(300);
    @(negedge clk); term = 1'b1; @(negedge clk); term = 1'b0; idle(4);
    cur_req = "R9 terminate during latency";
    issue(7'b011_0_011, 1'b1, 8'h30);
    term = 1'b1; @(negedge clk); term = 1'b0; idle(8);
    cur_req = "R9 terminate mid burst";
    issue(7'b010_0_011, 1'b0, 8'h50); idle(2);
    term = 1'b1; @(negedge clk); term = 1'b0; idle(8);
    cur_req = "R10 restart mid burst";
    issue(7'b011_0_011, 1'b0, 8'h60); idle(3);
    issue(7'b010_1_010, 1'b1, 8'h9B); idle(8);
    cur_req = "R12 inputs changed after capture";
    issue(7'b011_1_011, 1'b1, 8'hA3);
    mode_word = 7'b010_0_111; is_read = 1'b0; start_col = 8'h00; idle(12);
    cur_req = "R9 term when idle";
    term = 1'b1; @(negedge clk); term = 1'b0; idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule